// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the device half of a receive DMA path. Host software builds a ring of 16-byte descriptors in memory. Each descriptor holds four 32-bit words: status at offset 0, control at offset 4, buffer address at offset 8, and an unused link word at offset 12. The block reads the descriptor it is pointing at, copies an incoming frame into that descriptor's buffer, and writes a completion status back. That status write hands the descriptor back to the host. The block then moves to the next descriptor in the ring.

Frames arrive one byte per beat on a valid/ready stream, with a last marker and an error flag on each beat. The sender must hold a beat stable until ready is seen high at a clock edge. The block pulls ready low in three cases:
- while it is stopped;
- while it is fetching a descriptor;
- while any memory access is outstanding.

Memory is reached through a single word-wide port. A request holds steady until `mem_ready` is high. Read data is taken in the same cycle that `mem_ready` is high. A software run bit gates reception. If the descriptor is still owned by the host, the frame is drained and discarded, and a one-cycle missed pulse is raised.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `mem_req`, `in_ready` and `missed` are all low.
- R2: While `rx_run` is low and no frame is in progress, `in_ready` stays low and no memory request is issued, even with a beat waiting on the input.
- R3: When a frame's first beat is waiting, the block reads the status word at the current descriptor. Only if that word's bit 31 (device-owned) is 1 does it read the control word (+4) and then the buffer address (+8). Only after those reads does it accept bytes.
- R4: Frame byte k is stored at buffer address + 4*(k/4), in byte lane k%4 (little-endian). A final partial word is written with a byte-enable mask covering only its low lanes. The buffer address is taken as word aligned.
- R5: No byte at index k equal to or above the buffer size (control bits 10:0) is written to memory. Such an overrun sets the error summary bit.
- R6: The write-back is one full-word write to the descriptor's status word. It carries bit 31 = 0, bit 8 = 1 (last descriptor), and bits 29:16 = the count of bytes received, saturating at 16383. It carries bit 15 = 1 if any beat had its error flag set or the buffer overran. All other bits are 0.
- R7: After a write-back, the next descriptor is at the current address + 16. If the used descriptor had control bit 25 set, the next descriptor is the ring base instead.
- R8: If the status word's bit 31 is 0, the frame is accepted and discarded, and nothing is written to memory. `missed` goes high for exactly one cycle, in the cycle after the last beat is accepted. The same descriptor is read again for the next frame.
- R9: Dropping `rx_run` during a frame lets that frame finish and be written back. While the block is stopped and between frames, the next descriptor is reset to `ring_base`.
- R10: A memory request keeps its address, direction and write data unchanged until `mem_ready` is high.
- R11: `in_ready` is never high in a cycle where `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_run | input | 1 | Receive enable |
| ring_base | input | AW | Byte address of descriptor 0 |
| in_valid | input | 1 | Frame beat valid |
| in_ready | output | 1 | Frame beat accepted at this edge when valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final beat of the frame |
| in_err | input | 1 | Beat carries a receive error |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid while mem_ready is high |
| missed | output | 1 | One-cycle pulse for a frame dropped on a host-owned descriptor |

## Verification
The hardest case to reach is a frame landing on a descriptor the host still holds. From the outside it looks like silence: no memory writes, and the pointer does not move. The bench clears the ownership bit of exactly the descriptor the ring should reach next and sends a full frame. It then confirms three things: one missed pulse, an untouched buffer and status, and the next frame landing in that same descriptor once it is re-armed. A stop issued partway through a frame is reached by lowering the run bit between two accepted beats. The restart is then checked to land at the ring base rather than where the ring had reached.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // Fixed field positions that host software decodes
  localparam int unsigned OWN_BIT = 31;
  localparam int unsigned EOR_BIT = 25;
  localparam int unsigned ES_BIT  = 15;
  localparam int unsigned LS_BIT  = 8;
  localparam int unsigned LEN_LSB = 16;
  localparam int unsigned LEN_W   = 14;

  localparam int unsigned DESC_STRIDE = 16;
  localparam int unsigned CTL_OFS     = 4;
  localparam int unsigned BUF_OFS     = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_CTL, ST_BUF, ST_RECV, ST_WORD, ST_DROP, ST_WB
  } seq_state_e;

  function automatic logic [31:0] make_status(input logic [LEN_W-1:0] len,
                                              input logic err);
    logic [31:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[ES_BIT]  = err;
    w[LS_BIT]  = 1'b1;
    w[OWN_BIT] = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          run,
  input  logic [AW-1:0] ring_base,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] desc_addr
);
  import rxr_pkg::*;

  logic fresh_q;
  logic load;

  // Load the base while stopped between frames, and once after reset
  assign load = idle && (!run || fresh_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_addr <= '0;
      fresh_q   <= 1'b1;
    end else if (load) begin
      desc_addr <= ring_base;
      fresh_q   <= 1'b0;
    end else if (advance) begin
      desc_addr <= wrap ? ring_base : desc_addr + AW'(DESC_STRIDE);
    end
  end
endmodule

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer #(
  parameter int SIZE_W = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     take,
  input  logic [7:0]               byte_in,
  input  logic [SIZE_W-1:0]        limit,
  input  logic                     flush,
  output logic [31:0]              word_q,
  output logic [3:0]               be_q,
  output logic [rxr_pkg::LEN_W-1:0] len_q,
  output logic [1:0]               lane,
  output logic                     fits,
  output logic                     over_q
);
  import rxr_pkg::*;

  assign lane = len_q[1:0];
  assign fits = len_q < LEN_W'(limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      be_q   <= '0;
      len_q  <= '0;
      over_q <= 1'b0;
    end else if (clear) begin
      be_q   <= '0;
      len_q  <= '0;
      over_q <= 1'b0;
    end else begin
      if (flush) be_q <= '0;
      if (take) begin
        if (len_q != {LEN_W{1'b1}}) len_q <= len_q + 1'b1;
        if (fits) begin
          word_q[{lane, 3'b000} +: 8] <= byte_in;
          be_q[lane] <= 1'b1;
        end else begin
          over_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxr_seq.sv
module rxr_seq #(
  parameter int AW     = 32,
  parameter int SIZE_W = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      in_valid,
  input  logic                      in_last,
  input  logic                      in_err,
  output logic                      in_ready,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [AW-1:0]             mem_addr,
  output logic [31:0]               mem_wdata,
  output logic [3:0]                mem_be,
  input  logic                      mem_ready,
  input  logic [31:0]               mem_rdata,
  input  logic [AW-1:0]             desc_addr,
  input  logic [31:0]               pk_word,
  input  logic [3:0]                pk_be,
  input  logic [rxr_pkg::LEN_W-1:0] pk_len,
  input  logic [1:0]                pk_lane,
  input  logic                      pk_fits,
  input  logic                      pk_over,
  output logic                      pk_clear,
  output logic                      pk_take,
  output logic                      pk_flush,
  output logic [SIZE_W-1:0]         size_q,
  output logic                      ring_adv,
  output logic                      eor_q,
  output logic                      idle,
  output logic                      missed
);
  import rxr_pkg::*;

  seq_state_e state_q, state_d;
  logic [AW-1:0] wptr_q;
  logic          last_q, err_q;
  logic          take, have_data;

  assign in_ready  = (state_q == ST_RECV) || (state_q == ST_DROP);
  assign take      = in_valid && in_ready;
  assign pk_take   = take && (state_q == ST_RECV);
  assign pk_clear  = (state_q == ST_STAT);
  assign idle      = (state_q == ST_IDLE);
  assign have_data = (pk_be != 4'd0) || pk_fits;

  always_comb begin
    state_d   = state_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    mem_be    = 4'hF;
    pk_flush  = 1'b0;
    ring_adv  = 1'b0;
    case (state_q)
      ST_IDLE: if (run && in_valid) state_d = ST_STAT;
      ST_STAT: begin
        mem_req = 1'b1;
        if (mem_ready) state_d = mem_rdata[OWN_BIT] ? ST_CTL : ST_DROP;
      end
      ST_CTL: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(CTL_OFS);
        if (mem_ready) state_d = ST_BUF;
      end
      ST_BUF: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(BUF_OFS);
        if (mem_ready) state_d = ST_RECV;
      end
      ST_RECV: begin
        if (take && ((pk_lane == 2'd3) || in_last)) begin
          if (have_data)    state_d = ST_WORD;
          else if (in_last) state_d = ST_WB;
        end
      end
      ST_WORD: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = wptr_q;
        mem_wdata = pk_word;
        mem_be    = pk_be;
        if (mem_ready) begin
          pk_flush = 1'b1;
          state_d  = last_q ? ST_WB : ST_RECV;
        end
      end
      ST_DROP: if (take && in_last) state_d = ST_IDLE;
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = make_status(pk_len, err_q || pk_over);
        if (mem_ready) begin
          ring_adv = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wptr_q  <= '0;
      size_q  <= '0;
      eor_q   <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
      missed  <= 1'b0;
    end else begin
      state_q <= state_d;
      missed  <= (state_q == ST_DROP) && take && in_last;
      if (state_q == ST_STAT) begin
        last_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (pk_take) begin
        if (in_last) last_q <= 1'b1;
        if (in_err)  err_q  <= 1'b1;
      end
      if (state_q == ST_CTL && mem_ready) begin
        size_q <= mem_rdata[SIZE_W-1:0];
        eor_q  <= mem_rdata[EOR_BIT];
      end
      if (state_q == ST_BUF && mem_ready) wptr_q <= mem_rdata[AW-1:0];
      if (state_q == ST_WORD && mem_ready) wptr_q <= wptr_q + AW'(4);
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW     = 32,
  parameter int SIZE_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_run,
  input  logic [AW-1:0] ring_base,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          missed
);
  import rxr_pkg::*;

  logic [AW-1:0]     desc_addr;
  logic [31:0]       pk_word;
  logic [3:0]        pk_be;
  logic [LEN_W-1:0]  pk_len;
  logic [1:0]        pk_lane;
  logic              pk_fits, pk_over, pk_clear, pk_take, pk_flush;
  logic [SIZE_W-1:0] size_q;
  logic              ring_adv, eor_q, idle;

  rxr_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .idle(idle), .run(rx_run),
    .ring_base(ring_base), .advance(ring_adv), .wrap(eor_q),
    .desc_addr(desc_addr)
  );

  rxr_byte_packer #(.SIZE_W(SIZE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(pk_clear), .take(pk_take),
    .byte_in(in_data), .limit(size_q), .flush(pk_flush),
    .word_q(pk_word), .be_q(pk_be), .len_q(pk_len), .lane(pk_lane),
    .fits(pk_fits), .over_q(pk_over)
  );

  rxr_seq #(.AW(AW), .SIZE_W(SIZE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(rx_run),
    .in_valid(in_valid), .in_last(in_last), .in_err(in_err),
    .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .desc_addr(desc_addr),
    .pk_word(pk_word), .pk_be(pk_be), .pk_len(pk_len), .pk_lane(pk_lane),
    .pk_fits(pk_fits), .pk_over(pk_over), .pk_clear(pk_clear),
    .pk_take(pk_take), .pk_flush(pk_flush), .size_q(size_q),
    .ring_adv(ring_adv), .eor_q(eor_q), .idle(idle), .missed(missed)
  );
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int AW     = 32,
  parameter int SIZE_W = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [3:0]    mem_be,
  input logic          mem_ready,
  input logic [31:0]   mem_rdata,
  input logic          missed,
  input logic [AW-1:0] desc_addr
);
  logic [AW-1:0] cbuf;
  logic [AW-1:0] csize;

  // Independent record of the buffer fetched for the current descriptor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbuf  <= '0;
      csize <= '0;
    end else if (mem_req && !mem_we && mem_ready) begin
      if (mem_addr == desc_addr + AW'(8)) cbuf  <= mem_rdata[AW-1:0];
      if (mem_addr == desc_addr + AW'(4)) csize <= AW'(mem_rdata[SIZE_W-1:0]);
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !mem_req && !in_ready && !missed);

  a_r5_inside_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && (mem_addr != desc_addr) |-> (mem_addr - cbuf) < csize);

  a_r4_low_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && (mem_addr != desc_addr) |->
      (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));

  a_r6_release_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && (mem_addr == desc_addr) |->
      !mem_wdata[31] && mem_wdata[8] && (mem_be == 4'hF));

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata) && $stable(mem_be));

  a_r11_no_take_during_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    missed |=> !missed);
endmodule

bind rx_ring_writer rxr_checker #(.AW(AW), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_be(mem_be), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
  .missed(missed), .desc_addr(desc_addr)
);

// File: tb/rx_ring_writer_bench.sv
`timescale 1ns/1ps
module rx_ring_writer_bench;
  localparam int AW   = 32;
  localparam int RB   = 32'h40;
  localparam int BUFB = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_run = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, mem_req, mem_we, mem_ready, missed;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  logic [31:0] mem [0:255];
  int checks = 0, fails = 0;
  int cyc = 0, missed_cnt = 0, req_cnt = 0;
  int cur = 0, fnum = 0;
  bit stall_en = 1'b0;

  always #5 clk = ~clk;

  rx_ring_writer u_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .rx_run(rx_run), .ring_base(RB),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_err(in_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .missed(missed)
  );

  assign mem_ready = !stall_en || (cyc[0] ^ cyc[2]);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (missed) missed_cnt <= missed_cnt + 1;
    if (mem_req) req_cnt <= req_cnt + 1;
    if (mem_req && mem_we && mem_ready)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int k);
    return 8'((f * 37 + k * 11 + 3) & 255);
  endfunction

  function automatic logic [7:0] rd_byte(input int a);
    return mem[(a >> 2) & 255][8 * (a % 4) +: 8];
  endfunction

  task automatic prep(input int size, input bit own);
    int d, b;
    d = RB + cur * 16;
    b = BUFB + cur * 128;
    mem[d >> 2]       = own ? 32'h8000_0000 : 32'h0;
    mem[(d + 4) >> 2] = (cur == 2 ? 32'h0200_0000 : 32'h0) | 32'(size);
    mem[(d + 8) >> 2] = 32'(b);
    mem[(d + 12) >> 2] = 32'h0;
    for (int w = 0; w < 32; w++) mem[(b >> 2) + w] = 32'hA5A5_A5A5;
  endtask

  task automatic send_byte(input logic [7:0] v, input bit last, input bit err);
    int t;
    in_valid = 1'b1; in_data = v; in_last = last; in_err = err;
    t = 0;
    while (!in_ready && t < 500) begin @(negedge clk); t++; end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
  endtask

  task automatic check_buf(input int len, input int size, input string req);
    int b, bad, first;
    logic [7:0] e, a;
    b = BUFB + cur * 128;
    bad = 0; first = -1;
    for (int k = 0; k < 128; k++) begin
      e = (k < len && k < size) ? pat(fnum, k) : 8'hA5;
      a = rd_byte(b + k);
      if (a !== e) begin bad++; if (first < 0) first = k; end
    end
    chk(bad == 0, req, (first < 0) ? 0 : 32'(rd_byte(b + first)),
        (first < 0) ? 0 : ((first < len && first < size) ? 32'(pat(fnum, first)) : 32'hA5));
  endtask

  task automatic run_frame(input int len, input int size, input int errpos,
                           input int stop_at);
    int d, t, lexp;
    bit es;
    logic [31:0] exp;
    d = RB + cur * 16;
    prep(size, 1'b1);
    for (int k = 0; k < len; k++) begin
      send_byte(pat(fnum, k), k == len - 1, k == errpos);
      if (k == stop_at) rx_run = 1'b0;
    end
    t = 0;
    while (mem[d >> 2][31] && t < 400) begin @(negedge clk); t++; end
    lexp = (len > 16383) ? 16383 : len;
    es = (errpos >= 0) || (len > size);
    exp = (32'(lexp) << 16) | (32'(es) << 15) | 32'h100;
    // R6 status contents, R7 right descriptor reached
    chk(mem[d >> 2] === exp, "R6 R7 status", mem[d >> 2], exp);
    // R4 packing, R5 buffer limit
    check_buf(len, size, "R4 R5 buffer");
    fnum++;
    cur = (cur + 1) % 3;
  endtask

  initial begin
    int s_list [6] = '{0, 2, 4, 5, 8, 64};
    int m0, r0, rdy, d;
    for (int w = 0; w < 256; w++) mem[w] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mem_req && !in_ready && !missed, "R1 reset",
        {29'd0, mem_req, in_ready, missed}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rx_run = 1'b1;

    // Sweep over frame length and buffer size (R3 R4 R5 R6 R7)
    for (int len = 1; len <= 9; len++)
      for (int si = 0; si < 6; si++) begin
        stall_en = (len % 2) == 1;
        run_frame(len, s_list[si], -1, -1);
      end

    // R6 error flag on a middle beat
    run_frame(6, 64, 3, -1);

    // R8 host-owned descriptor: frame dropped, same descriptor reused
    d = RB + cur * 16;
    prep(64, 1'b0);
    m0 = missed_cnt;
    for (int k = 0; k < 5; k++) send_byte(8'h5A, k == 4, 1'b0);
    repeat (4) @(negedge clk);
    chk(missed_cnt == m0 + 1, "R8 missed pulse", 32'(missed_cnt - m0), 32'd1);
    chk(mem[d >> 2] === 32'h0, "R8 status untouched", mem[d >> 2], 32'h0);
    check_buf(0, 0, "R8 buffer untouched");
    run_frame(7, 64, -1, -1);

    // R9 stop mid-frame: frame completes; R2 nothing taken while stopped
    while (cur != 0) run_frame(3, 64, -1, -1);
    run_frame(7, 64, -1, 2);
    r0 = req_cnt;
    rdy = 0;
    in_valid = 1'b1; in_data = pat(fnum, 0); in_last = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (in_ready) rdy++;
    end
    chk(rdy == 0, "R2 ready while stopped", 32'(rdy), 32'd0);
    chk(req_cnt == r0, "R2 memory while stopped", 32'(req_cnt - r0), 32'd0);
    // R9 restart lands at ring base (cur was 1)
    cur = 0;
    rx_run = 1'b1;
    run_frame(5, 64, -1, -1);

    // R6 length saturation on a long frame, with overrun
    stall_en = 1'b0;
    run_frame(16390, 8, -1, -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule